// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block measures how fast a fan turns by timing the gap between qualifying edges on its tachometer pulse line. The tach line is asynchronous to the block clock, so it is brought into the clock domain by a short flop chain before its edges are detected. A programmable prescaler turns the block clock into slower count ticks. The measurement counts those ticks from one qualifying edge to the next.

Software sets the edge mode, the prescaler select and the window length. It then toggles the trigger low and then high to start a run. When the run ends, `done` goes high and `count` holds the tick count. Two conditions end a run with `done` high and a count of zero: the window runs out before the closing edge arrives, or the edge mode never accepts any edge. Converting the count to a rotation rate is left to software.

Top module: `tach_period_meter`

## Requirements
- R1: During and right after reset, `done` is 0 and `count` is 0.
- R2: A measurement starts on the first cycle in which `trigger` is 1 after having been 0, provided `chan_en` is 1. Starting clears `done` and `count`. Holding `trigger` at 1 does not start another run.
- R3: With `edge_mode` = 2'b01, only rising edges qualify. The result is the number of ticks from one rising edge to the next rising edge.
- R4: With `edge_mode` = 2'b00, only falling edges qualify. The result is the number of ticks from one falling edge to the next falling edge.
- R5: With `edge_mode` = 2'b10, edges of either polarity qualify. The result spans two adjacent edges, so for a square wave it is half the single-polarity result.
- R6: With `edge_mode` = 2'b11, no edge qualifies. The run ends when the window expires, with `done` = 1 and `count` = 0.
- R7: One tick is (4 << (2 × `div_sel`)) clock cycles, giving divide ratios of 4, 16, 64 and 256 for `div_sel` values 0 to 3.
- R8: The window lasts `unit` × 16 ticks and is timed from the start. If it expires before the closing edge arrives, the run ends with `done` = 1 and `count` = 0. A `unit` of 0 ends the run within two cycles of the start.
- R9: A new 0-to-1 transition of `trigger` during a run, or after a run, discards the old run and its result. Only edges after the new start are used.
- R10: While `chan_en` is 0, triggers are ignored. `done` and `count` read 0 one cycle after `chan_en` falls, and this also aborts any run in progress.
- R11: The count saturates at all ones for its width (0xFFFFF at the default 20 bits) and never wraps.
- R12: `count` stays 0 until `done` rises. After that, `count` and `done` hold, whatever the tach line does, until the next start, a disable, or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_in | input | 1 | Raw tachometer pulse line, asynchronous |
| chan_en | input | 1 | Channel enable |
| edge_mode | input | 2 | 00 falling, 01 rising, 10 both, 11 none |
| div_sel | input | DIV_W (2) | Tick prescaler select, divide by 4 << (2 × value) |
| unit | input | UNIT_W (16) | Window length in units of 16 ticks |
| trigger | input | 1 | Start request, acts on a 0-to-1 transition |
| done | output | 1 | Measurement finished |
| count | output | CNT_W (20) | Ticks between qualifying edges, 0 on timeout |

## Verification
The hardest case to reach from the ports is count saturation. At the default width it needs about a million ticks, which is more than four million clock cycles. The bench therefore runs a second instance with a 6-bit count on the same inputs, so a gap of 110 ticks must read 63 on that instance. Polarity selection is also hard to observe, because a square wave gives the same period for rising and falling edges. To separate them, every stimulus is a four-edge pattern whose high and low gaps differ, so the rising, falling and both-edge results are all distinct numbers.

// File: rtl/tach_meter_pkg.sv
package tach_meter_pkg;

    typedef enum logic [1:0] {
        EM_FALL = 2'b00,
        EM_RISE = 2'b01,
        EM_BOTH = 2'b10,
        EM_NONE = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ARM  = 2'b01,
        ST_MEAS = 2'b10
    } meas_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    // Fixed scale between the unit input and the window length in ticks
    localparam int unsigned WIN_SHIFT = 4;

    function automatic logic edge_hit(edge_mode_e m, edge_pair_t e);
        case (m)
            EM_FALL: return e.fall;
            EM_RISE: return e.rise;
            EM_BOTH: return e.rise | e.fall;
            default: return 1'b0;
        endcase
    endfunction

    // Terminal prescaler value for a select code: divide ratio minus one
    function automatic int unsigned presc_last(int unsigned sel);
        return (32'd4 << (2 * sel)) - 32'd1;
    endfunction

endpackage

// File: rtl/tach_edge_det.sv
module tach_edge_det
    import tach_meter_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tach_in,
    output edge_pair_t edges
);
    // Synchroniser stages plus one history flop for edge detection
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= tach_in;
    end

    for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
        end
    end

    always_comb begin
        edges.rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
        edges.fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];
    end
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler
    import tach_meter_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int PRE_W = 2 + 2 * ((1 << DIV_W) - 1);

    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] last;

    assign last = PRE_W'(presc_last(32'(div_sel)));
    assign tick = (pcnt >= last);

    always_ff @(posedge clk) begin
        if (rst || restart) pcnt <= '0;
        else if (tick)      pcnt <= '0;
        else                pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/tach_meas_fsm.sv
module tach_meas_fsm
    import tach_meter_pkg::*;
#(
    parameter int UNIT_W = 16,
    parameter int CNT_W  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic              start,
    input  logic              tick,
    input  logic              hit,
    input  logic [UNIT_W-1:0] unit,
    output logic              done,
    output logic [CNT_W-1:0]  result
);
    localparam int LIM_W = UNIT_W + WIN_SHIFT;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meas_state_e      st;
    logic [CNT_W-1:0] cnt;
    logic [LIM_W-1:0] win;
    logic [LIM_W-1:0] limit;
    logic             expired;
    logic [CNT_W-1:0] cnt_next;

    assign limit    = {unit, {WIN_SHIFT{1'b0}}};
    assign expired  = (win >= limit);
    assign cnt_next = (tick && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;

    always_ff @(posedge clk) begin
        if (rst || !chan_en) begin
            st     <= ST_IDLE;
            done   <= 1'b0;
            result <= '0;
            cnt    <= '0;
            win    <= '0;
        end else if (start) begin
            st     <= ST_ARM;
            done   <= 1'b0;
            result <= '0;
            cnt    <= '0;
            win    <= '0;
        end else begin
            if (st != ST_IDLE && tick && !expired) win <= win + 1'b1;
            case (st)
                ST_ARM: begin
                    if (hit) begin
                        st  <= ST_MEAS;
                        cnt <= '0;
                    end else if (expired) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                ST_MEAS: begin
                    if (hit) begin
                        st     <= ST_IDLE;
                        done   <= 1'b1;
                        result <= cnt_next;
                    end else if (expired) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt_next;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tach_period_meter.sv
module tach_period_meter
    import tach_meter_pkg::*;
#(
    parameter int DIV_W       = 2,
    parameter int UNIT_W      = 16,
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tach_in,
    input  logic              chan_en,
    input  logic [1:0]        edge_mode,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [UNIT_W-1:0] unit,
    input  logic              trigger,
    output logic              done,
    output logic [CNT_W-1:0]  count
);
    logic       trg_q;
    logic       start;
    logic       tick;
    logic       hit;
    edge_pair_t edges;

    always_ff @(posedge clk) begin
        if (rst) trg_q <= 1'b0;
        else     trg_q <= trigger;
    end

    assign start = trigger & ~trg_q & chan_en;
    assign hit   = edge_hit(edge_mode_e'(edge_mode), edges);

    tach_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .tach_in (tach_in),
        .edges   (edges)
    );

    tach_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .div_sel (div_sel),
        .tick    (tick)
    );

    tach_meas_fsm #(.UNIT_W(UNIT_W), .CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .chan_en (chan_en),
        .start   (start),
        .tick    (tick),
        .hit     (hit),
        .unit    (unit),
        .done    (done),
        .result  (count)
    );
endmodule

// File: rtl/tach_period_meter_chk.sv
module tach_period_meter_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             chan_en,
    input logic             trigger,
    input logic             done,
    input logic [CNT_W-1:0] count
);
    logic trg_seen;
    logic new_start;

    always_ff @(posedge clk) begin
        if (rst) trg_seen <= 1'b0;
        else     trg_seen <= trigger;
    end

    assign new_start = trigger && !trg_seen && chan_en;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!done && count == '0));

    // R2, R9
    a_r2_start_clears_done: assert property (@(posedge clk) disable iff (rst)
        new_start |=> !done);

    // R10
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> (!done && count == '0));

    // R12
    a_r12_result_held: assert property (@(posedge clk) disable iff (rst)
        (done && chan_en && !new_start) |=> (done && $stable(count)));

    // R12
    a_r12_no_value_pending: assert property (@(posedge clk) disable iff (rst)
        !done |-> (count == '0));
endmodule

bind tach_period_meter tach_period_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .chan_en (chan_en),
    .trigger (trigger),
    .done    (done),
    .count   (count)
);

// File: tb/sim_tach_period_meter.sv
module sim_tach_period_meter;
    localparam int NV   = 10;
    localparam int LEAD = 20;

    // columns: edge mode, div select, unit, gap1, gap2, gap3
    localparam int VMODE [NV] = '{1, 0, 2, 2, 1, 0, 1, 1, 3, 0};
    localparam int VDIV  [NV] = '{0, 0, 0, 0, 1, 2, 3, 0, 0, 0};
    localparam int VUNIT [NV] = '{528, 528, 528, 528, 528, 528, 528, 1, 4, 5};
    localparam int VG1   [NV] = '{40, 40, 40, 80, 64, 128, 512, 40, 40, 40};
    localparam int VG2   [NV] = '{160, 160, 160, 80, 192, 640, 1024, 160, 40, 160};
    localparam int VG3   [NV] = '{200, 200, 200, 80, 64, 128, 256, 200, 40, 200};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tach_in = 1'b0;
    logic        chan_en = 1'b1;
    logic [1:0]  edge_mode = 2'b01;
    logic [1:0]  div_sel = 2'd0;
    logic [15:0] unit = 16'h0210;
    logic        trigger = 1'b0;
    logic        done, done_s;
    logic [19:0] count;
    logic [5:0]  count_s;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tach_period_meter u0 (
        .clk(clk), .rst(rst), .tach_in(tach_in), .chan_en(chan_en),
        .edge_mode(edge_mode), .div_sel(div_sel), .unit(unit),
        .trigger(trigger), .done(done), .count(count)
    );

    tach_period_meter #(.CNT_W(6)) u1 (
        .clk(clk), .rst(rst), .tach_in(tach_in), .chan_en(chan_en),
        .edge_mode(edge_mode), .div_sel(div_sel), .unit(unit),
        .trigger(trigger), .done(done_s), .count(count_s)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire();
        trigger = 1'b0;
        cycles(2);
        trigger = 1'b1;
        cycles(1);
    endtask

    task automatic pattern(int g1, int g2, int g3);
        tach_in = 1'b1; cycles(g1);
        tach_in = 1'b0; cycles(g2);
        tach_in = 1'b1; cycles(g3);
        tach_in = 1'b0; cycles(10);
    endtask

    task automatic wait_done(int lim);
        for (int k = 0; k < lim && !done; k++) cycles(1);
    endtask

    function automatic int expect_of(int m, int d, int u, int g1, int g2, int g3);
        int dv = 4 << (2 * d);
        int win = 16 * u * dv;
        int t, v;
        case (m)
            1: begin t = LEAD + g1 + g2;      v = (g1 + g2) / dv; end
            0: begin t = LEAD + g1 + g2 + g3; v = (g2 + g3) / dv; end
            2: begin t = LEAD + g1;           v = g1 / dv; end
            default: return 0;
        endcase
        return (t < win) ? v : 0;
    endfunction

    function automatic string tag_of(int i);
        case (i)
            0: return "R3 rising";
            1: return "R4 falling";
            2: return "R5 both uneven";
            3: return "R5 both half period";
            4, 5, 6: return "R7 divider";
            7: return "R8 window expiry";
            8: return "R6 no edge mode";
            default: return "R8 window falling";
        endcase
    endfunction

    initial begin
        cycles(4);
        check("R1 done in reset", done, 0);
        rst = 1'b0;
        cycles(1);
        check("R1 count after reset", count, 0);
        check("R1 done after reset", done, 0);

        // Table of vectors
        for (int i = 0; i < NV; i++) begin
            edge_mode = VMODE[i][1:0];
            div_sel = VDIV[i][1:0];
            unit = VUNIT[i][15:0];
            fire();
            cycles(LEAD - 1);
            pattern(VG1[i], VG2[i], VG3[i]);
            wait_done(70000);
            check({tag_of(i), " done"}, done, 1);
            check({tag_of(i), " count"}, count,
                  expect_of(VMODE[i], VDIV[i], VUNIT[i], VG1[i], VG2[i], VG3[i]));
        end

        // R12: result holds while tach keeps toggling and trigger stays high
        edge_mode = 2'b01; div_sel = 2'd0; unit = 16'h0210;
        fire(); cycles(LEAD - 1);
        pattern(40, 160, 200);
        wait_done(1000);
        pattern(20, 20, 20);
        check("R12 done held", done, 1);
        check("R12 count held", count, 50);

        // R9 / R2: retrigger clears, then restart discards old edge
        fire();
        check("R2 done cleared by start", done, 0);
        check("R2 count cleared by start", count, 0);
        tach_in = 1'b1; cycles(30);
        fire();
        check("R9 done clear on retrigger", done, 0);
        tach_in = 1'b0; cycles(LEAD);
        pattern(40, 160, 200);
        wait_done(1000);
        check("R9 restart count", count, 50);

        // R11: saturation on the narrow instance
        fire(); cycles(LEAD - 1);
        pattern(40, 400, 40);
        wait_done(1000);
        check("R11 wide count", count, 110);
        check("R11 narrow count saturates", count_s, 63);
        check("R11 narrow done", done_s, 1);

        // R8: unit of zero ends immediately
        unit = 16'd0;
        fire();
        cycles(2);
        check("R8 zero window done", done, 1);
        check("R8 zero window count", count, 0);
        unit = 16'h0210;

        // R10: disabled channel ignores trigger
        chan_en = 1'b0;
        cycles(2);
        check("R10 disable clears done", done, 0);
        fire(); cycles(LEAD - 1);
        pattern(40, 160, 200);
        cycles(50);
        check("R10 no result while disabled", done, 0);
        check("R10 count zero while disabled", count, 0);

        // R10: dropping enable aborts a run
        chan_en = 1'b1;
        fire();
        tach_in = 1'b1; cycles(10);
        chan_en = 1'b0; cycles(1);
        tach_in = 1'b0; cycles(10);
        tach_in = 1'b1; cycles(10);
        chan_en = 1'b1; cycles(5);
        check("R10 aborted run no done", done, 0);
        tach_in = 1'b0; cycles(5);

        // R1: reset after a finished run
        fire(); cycles(LEAD - 1);
        pattern(40, 160, 200);
        wait_done(1000);
        rst = 1'b1; cycles(1);
        rst = 1'b0; cycles(1);
        check("R1 reset clears done", done, 0);
        check("R1 reset clears count", count, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule